// File: doc/BRIEF.md
# Long Packet Payload CRC-16

This block produces the 16-bit checksum that closes a long packet on a serial camera link. Payload bytes enter one per clock with a valid strobe. A start strobe opens a packet and samples its word count, and a last strobe marks the final byte. When the packet ends, the block registers the finished checksum. A transmitter appends that value to the packet as its footer, low byte first.

The same engine also serves the receiver. With checking enabled, the footer taken from the wire is presented alongside the final byte. The block compares it with the locally computed value and raises a one-cycle error pulse on a mismatch. The checksum only detects corruption: nothing is corrected.

The accumulator is reseeded with all ones by every start strobe. A packet whose word count is zero carries no payload, and its checksum is all ones by definition.

Top module: `lpkt_crc16`

## Requirements
- R1: While reset is held low, `crc_o` is 0xFFFF and both `done_o` and `crc_err_o` are 0.
- R2: The checksum uses the generator x^16 + x^12 + x^5 + 1, processes each byte least-significant bit first, starts from 0xFFFF and applies no final inversion. The ASCII bytes "123456789" therefore give 0x6F91. Bits [7:0] of `crc_o` form the footer byte sent first.
- R3: `start_i` discards any partly accumulated value and reseeds the register with 0xFFFF before the byte of that cycle is folded in. This holds even when the previous packet never saw `last_i`.
- R4: One byte is absorbed on each cycle where `valid_i` is 1. Cycles with `valid_i` low leave the accumulation unchanged, whatever is on `data_i`.
- R5: A packet ends on a cycle with `valid_i` and `last_i` both high. In the next cycle `done_o` is high for exactly one cycle and `crc_o` shows the result. `crc_o` then holds until the next packet ends.
- R6: When `start_i` is high and `wcount_i` is 0, the packet ends in that cycle. The result is 0xFFFF, and any byte presented in that cycle is ignored.
- R7: When `chk_en_i` is high on the end cycle and `footer_i` on that cycle differs from the computed checksum, `crc_err_o` pulses together with `done_o`. `crc_err_o` is never high without `done_o`.
- R8: `crc_err_o` stays low when the footer matches, and it stays low when `chk_en_i` is low on the end cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Opens a packet, reseeds, samples word count |
| wcount_i | input | 16 | Payload word count, sampled with `start_i` |
| valid_i | input | 1 | `data_i` holds a payload byte |
| data_i | input | 8 | Payload byte |
| last_i | input | 1 | Marks the final payload byte (with `valid_i`) |
| chk_en_i | input | 1 | Enables the receive-side footer compare |
| footer_i | input | 16 | Received footer, presented on the end cycle |
| crc_o | output | 16 | Finished checksum, low byte transmitted first |
| done_o | output | 1 | One-cycle pulse: `crc_o` updated |
| crc_err_o | output | 1 | One-cycle pulse: footer mismatch |

## Verification
The checker module watches the block on every cycle. It checks that an end event is followed by exactly one `done_o` pulse, and that `crc_o` never moves without one. It also checks that an empty packet yields all ones, that the error pulse equals the footer comparison, and that the error pulse is silent while checking is disabled. The arithmetic itself is shown only by the bench scenarios. These compare results against an independent model and a known check vector, and they cover reseeding in mid-packet, gaps in the byte stream, and empty packets that carry a stray byte.

// File: rtl/lpkt_crc16_pkg.sv
package lpkt_crc16_pkg;

  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Mirror a checksum-wide word end for end.
  function automatic crc_t bit_reverse(input crc_t v);
    crc_t r;
    for (int i = 0; i < CRC_W; i++) begin
      r[i] = v[CRC_W-1-i];
    end
    return r;
  endfunction

  // Fold one byte into a right-shifting (reflected) register, bit 0 first.
  function automatic crc_t fold_byte(input crc_t c, input byte_t d, input crc_t poly_rev);
    crc_t r;
    logic fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) begin
        r = r ^ poly_rev;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/lpkt_crc_accum.sv
module lpkt_crc_accum
  import lpkt_crc16_pkg::*;
#(
  parameter crc_t SEED     = 16'hFFFF,
  parameter crc_t POLY_REV = 16'h8408,
  parameter int   WC_W     = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [WC_W-1:0] wcount_i,
  input  logic            valid_i,
  input  byte_t           data_i,
  input  logic            last_i,
  output crc_t            res_o,
  output logic            end_o,
  output logic            empty_o
);

  crc_t acc_q;
  crc_t base;
  crc_t folded;
  crc_t nxt;

  always_comb begin
    empty_o = start_i && (wcount_i == '0);
    base    = start_i ? SEED : acc_q;
    folded  = fold_byte(base, data_i, POLY_REV);
    if (empty_o) begin
      nxt = SEED;
    end else if (valid_i) begin
      nxt = folded;
    end else begin
      nxt = base;
    end
    end_o = empty_o || (valid_i && last_i);
    res_o = nxt;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      acc_q <= SEED;
    end else begin
      acc_q <= nxt;
    end
  end

endmodule

// File: rtl/lpkt_crc_result.sv
module lpkt_crc_result
  import lpkt_crc16_pkg::*;
#(
  parameter crc_t SEED = 16'hFFFF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic end_i,
  input  crc_t res_i,
  input  logic chk_en_i,
  input  crc_t footer_i,
  output crc_t crc_o,
  output logic done_o,
  output logic crc_err_o
);

  logic mismatch;

  always_comb begin
    mismatch = chk_en_i && (res_i != footer_i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      crc_o     <= SEED;
      done_o    <= 1'b0;
      crc_err_o <= 1'b0;
    end else begin
      done_o    <= end_i;
      crc_err_o <= end_i && mismatch;
      if (end_i) begin
        crc_o <= res_i;
      end
    end
  end

endmodule

// File: rtl/lpkt_crc16.sv
module lpkt_crc16
  import lpkt_crc16_pkg::*;
#(
  parameter crc_t POLY = 16'h1021,
  parameter crc_t SEED = 16'hFFFF,
  parameter int   WC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [WC_W-1:0] wcount_i,
  input  logic            valid_i,
  input  logic [7:0]      data_i,
  input  logic            last_i,
  input  logic            chk_en_i,
  input  logic [15:0]     footer_i,
  output logic [15:0]     crc_o,
  output logic            done_o,
  output logic            crc_err_o
);

  localparam crc_t POLY_REV = bit_reverse(POLY);

  // Named internal events, visible to the bound checker.
  crc_t pkt_res;
  logic pkt_end;
  logic pkt_empty;

  lpkt_crc_accum #(
    .SEED     (SEED),
    .POLY_REV (POLY_REV),
    .WC_W     (WC_W)
  ) accum_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .wcount_i (wcount_i),
    .valid_i  (valid_i),
    .data_i   (data_i),
    .last_i   (last_i),
    .res_o    (pkt_res),
    .end_o    (pkt_end),
    .empty_o  (pkt_empty)
  );

  lpkt_crc_result #(
    .SEED (SEED)
  ) result_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .end_i     (pkt_end),
    .res_i     (pkt_res),
    .chk_en_i  (chk_en_i),
    .footer_i  (footer_i),
    .crc_o     (crc_o),
    .done_o    (done_o),
    .crc_err_o (crc_err_o)
  );

endmodule

// File: rtl/lpkt_crc16_chk.sv
module lpkt_crc16_chk #(
  parameter logic [15:0] SEED = 16'hFFFF
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        chk_en_i,
  input logic [15:0] footer_i,
  input logic [15:0] crc_o,
  input logic        done_o,
  input logic        crc_err_o,
  input logic        pkt_end,
  input logic        pkt_empty
);

  // R5
  done_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end |=> done_o);

  // R5
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_end |=> !done_o);

  // R5
  crc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_end |=> $stable(crc_o));

  // R6
  empty_all_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_empty |=> (crc_o == SEED));

  // R7
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |-> done_o);

  // R7
  err_matches_compare_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end && chk_en_i) |=> (crc_err_o == (crc_o != $past(footer_i))));

  // R8
  err_silent_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_en_i |=> !crc_err_o);

endmodule

bind lpkt_crc16 lpkt_crc16_chk #(.SEED(SEED)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chk_en_i  (chk_en_i),
  .footer_i  (footer_i),
  .crc_o     (crc_o),
  .done_o    (done_o),
  .crc_err_o (crc_err_o),
  .pkt_end   (pkt_end),
  .pkt_empty (pkt_empty)
);

// File: tb/lpkt_crc16_tb_top.sv
module lpkt_crc16_tb_top;

  localparam int CLK_PERIOD_NS = 10;
  localparam int WATCHDOG_CYC  = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] wcount;
  logic        valid;
  logic [7:0]  data;
  logic        last;
  logic        chk_en;
  logic [15:0] footer;
  logic [15:0] crc;
  logic        done;
  logic        crc_err;

  always #(CLK_PERIOD_NS/2) clk = ~clk;

  lpkt_crc16 dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .wcount_i  (wcount),
    .valid_i   (valid),
    .data_i    (data),
    .last_i    (last),
    .chk_en_i  (chk_en),
    .footer_i  (footer),
    .crc_o     (crc),
    .done_o    (done),
    .crc_err_o (crc_err)
  );

  typedef struct {
    logic [15:0] crc;
    logic        err;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_err = 0;
  bit          finished = 1'b0;
  bit          after_done = 1'b0;
  logic [15:0] held_crc;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Independent model: left-shifting register on mirrored bits, mirrored result.
  function automatic logic [15:0] ref_crc(input logic [7:0] pl[$]);
    logic [15:0] r;
    logic [15:0] o;
    logic        fb;
    r = 16'hFFFF;
    foreach (pl[j]) begin
      for (int k = 0; k < 8; k++) begin
        fb = r[15] ^ pl[j][k];
        r  = {r[14:0], 1'b0};
        if (fb) r = r ^ 16'h1021;
      end
    end
    for (int k = 0; k < 16; k++) o[k] = r[15-k];
    return o;
  endfunction

  task automatic drive_idle();
    start = 1'b0;
    valid = 1'b0;
    last  = 1'b0;
    data  = 8'($urandom);
  endtask

  task automatic send_pkt(input logic [7:0] pl[$], input bit gaps, input bit chk,
                          input bit corrupt, input string req,
                          input bit use_known, input logic [15:0] known);
    exp_t        e;
    logic [15:0] expv;
    logic [15:0] ftr;
    expv  = use_known ? known : ref_crc(pl);
    ftr   = corrupt ? (expv ^ 16'h0100) : expv;
    e.crc = expv;
    e.err = chk && corrupt;
    e.req = req;
    sb.push_back(e);
    if (pl.size() == 0) begin
      @(negedge clk);
      start = 1'b1; wcount = 16'd0; valid = 1'b1; data = 8'hA5; last = 1'b0;
      chk_en = chk; footer = ftr;
    end else begin
      for (int i = 0; i < pl.size(); i++) begin
        if (gaps && i > 0 && (i % 3) == 0) begin
          @(negedge clk);
          drive_idle();
        end
        @(negedge clk);
        start  = (i == 0);
        wcount = 16'(pl.size());
        valid  = 1'b1;
        data   = pl[i];
        last   = (i == pl.size() - 1);
        chk_en = chk;
        footer = ftr;
      end
    end
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    drive_idle();
  endtask

  // Monitor: pops the scoreboard on each completion, checks the hold afterwards.
  always @(negedge clk) begin
    if (rst_n) begin
      if (after_done) begin
        check(!done, "R5", "done width", {31'd0, done}, 32'd0);
        check(crc == held_crc, "R5", "crc hold", {16'd0, crc}, {16'd0, held_crc});
        after_done <= 1'b0;
      end
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R5", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(crc == e.crc, e.req, "checksum", {16'd0, crc}, {16'd0, e.crc});
          check(crc_err == e.err, e.req, "error pulse", {31'd0, crc_err}, {31'd0, e.err});
        end
        held_crc   <= crc;
        after_done <= 1'b1;
      end else begin
        check(!crc_err, "R7", "error without done", {31'd0, crc_err}, 32'd0);
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] pl[$];
    void'($urandom(32'h5eed));
    rst_n  = 1'b0;
    wcount = 16'd0;
    chk_en = 1'b0;
    footer = 16'd0;
    drive_idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(crc == 16'hFFFF, "R1", "reset crc", {16'd0, crc}, 32'hFFFF);
    check(!done, "R1", "reset done", {31'd0, done}, 32'd0);
    check(!crc_err, "R1", "reset err", {31'd0, crc_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 known check vector, receive side with matching footer
    pl = {};
    for (int i = 0; i < 9; i++) pl.push_back(8'h31 + 8'(i));
    send_pkt(pl, 1'b0, 1'b1, 1'b0, "R2", 1'b1, 16'h6F91);

    // R2 single byte
    pl = {8'h00};
    send_pkt(pl, 1'b0, 1'b0, 1'b0, "R2", 1'b0, 16'h0);

    // R4 assorted lengths, with and without idle gaps
    for (int n = 2; n <= 17; n += 5) begin
      pl = {};
      for (int i = 0; i < n; i++) pl.push_back(8'($urandom));
      send_pkt(pl, (n % 2) == 1, 1'b0, 1'b0, "R4", 1'b0, 16'h0);
    end

    // R3 abandoned packet, then a fresh start
    @(negedge clk);
    start = 1'b1; wcount = 16'd8; valid = 1'b1; data = 8'h5A; last = 1'b0;
    @(negedge clk);
    start = 1'b0; data = 8'hC3;
    @(negedge clk);
    data = 8'h7E;
    pl = {8'h10, 8'h20, 8'h30, 8'h40};
    send_pkt(pl, 1'b0, 1'b1, 1'b0, "R3", 1'b0, 16'h0);

    // R6 empty packets with a stray byte; R7 empty with bad footer
    pl = {};
    send_pkt(pl, 1'b0, 1'b1, 1'b0, "R6", 1'b0, 16'h0);
    send_pkt(pl, 1'b0, 1'b1, 1'b1, "R7", 1'b0, 16'h0);

    // R7 mismatch, R8 match and disabled compare
    pl = {8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h01};
    send_pkt(pl, 1'b1, 1'b1, 1'b1, "R7", 1'b0, 16'h0);
    send_pkt(pl, 1'b0, 1'b1, 1'b0, "R8", 1'b0, 16'h0);
    send_pkt(pl, 1'b0, 1'b0, 1'b1, "R8", 1'b0, 16'h0);

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R5", "pending results", sb.size(), 32'd0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule